// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Core with Selectable Read Latency

This block is a single-port synchronous memory that sits behind a registered address and control interface. On every rising clock edge it captures an address, two chip enables and a write command. The write command has three parts: a global write that stores every byte lane, a byte-write enable, and one select per lane that picks the lanes a byte write stores. Each lane is nine bits wide, and its top bit carries parity, which is stored with its byte. The depth and the number of lanes are parameters.

Reads come back by one of two paths, picked by a static mode input. In flow-through mode the stored word is driven straight from the array once the read address has been registered. In pipelined mode it first passes through a rising-edge output register, which adds one clock of latency. Output enable and sleep act on the outputs without waiting for a clock. Sleep also blocks every access, and stored contents are kept while it is asserted. High impedance is shown by the drive flag `q_drive` being low, and `q` reads as zero while the flag is low. The read stream is valid-only: `q_drive` acts as the valid, and there is no ready, because a memory core cannot stall. A consumer must take a word in the cycle in which it is driven.

Top module: `sram_core`

## Requirements
- R1: An access occurs only when `cs_n` is 0 and `cs` is 1 on the clock edge. Otherwise nothing is written and no read data is driven for that cycle.
- R2: When `wr_all` is 1 on a selected edge, all lanes of `d` are stored at `addr`, whatever `wr_bytes` and `lane_sel` are.
- R3: When `wr_all` is 0, a write occurs only if `wr_bytes` is 1. Then only the lanes whose `lane_sel` bit is 1 are stored; lane k is `d[9k+8:9k]`. When `wr_all` and `wr_bytes` are both 0, `lane_sel` has no effect.
- R4: With `pipe_mode` at 0 (flow-through), the word at a read address registered at edge E is driven on `q` in the cycle that follows E.
- R5: With `pipe_mode` at 1 (pipelined), that word is driven in the cycle that follows edge E+1.
- R6: `oe` is asynchronous. While `oe` is 0, `q_drive` is 0 and `q` is 0, and driving resumes as soon as `oe` returns to 1.
- R7: `sleep` is asynchronous. While `sleep` is 1, `q_drive` is 0 and no write takes effect. Stored data survives sleep.
- R8: Deselect takes one cycle. In pipelined mode, a deselect registered at edge E still lets the read from edge E-1 be driven after E, and `q_drive` is 0 after E+1. In flow-through mode, `q_drive` is 0 right after E.
- R9: After reset, and in any cycle that is a write cycle, `q_drive` is 0 and `q` is 0.
- R10: The ninth bit of each lane is written and read together with its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| addr | input | ADDR_W | Word address, registered on the edge |
| cs_n | input | 1 | Active-low chip enable |
| cs | input | 1 | Active-high chip enable |
| wr_all | input | 1 | Global write: store every lane |
| wr_bytes | input | 1 | Byte-write enable |
| lane_sel | input | LANES | Per-lane select for byte writes |
| d | input | LANES*LANE_W | Write data, lane k at bits 9k+8..9k |
| pipe_mode | input | 1 | 0 flow-through, 1 pipelined (static) |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_drive | output | 1 | Read data valid / not high impedance |

## Verification
The bench builds the core with its default parameters: a 64-word depth and two 9-bit lanes, which is the by-18 arrangement. Two lanes are enough to reach every mix of lane selects: none, either single lane, and both. They also let the bench exercise the parity bit of each lane separately. A small depth keeps the reads and writes at several addresses cheap, and each of those addresses can be read back in both latency modes.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int LANES = 2
) (
  input  logic             selected,
  input  logic             sleep,
  input  logic             wr_all,
  input  logic             wr_bytes,
  input  logic [LANES-1:0] lane_sel,
  output sram_pkg::cyc_kind_e kind,
  output logic [LANES-1:0] lane_we
);
  import sram_pkg::*;

  logic go;
  assign go = selected && !sleep;

  always_comb begin
    if (!go)                    kind = CYC_IDLE;
    else if (wr_all || wr_bytes) kind = CYC_WRITE;
    else                        kind = CYC_READ;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (kind != CYC_WRITE) lane_we[l] = 1'b0;
      else if (wr_all)       lane_we[l] = 1'b1;
      else                   lane_we[l] = lane_sel[l];
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rword[l*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/sram_out_path.sv
module sram_out_path #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_pkg::rd_mode_e mode,
  input  logic              rd_q,
  input  logic [DATA_W-1:0] rword,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] q,
  output logic              q_drive
);
  import sram_pkg::*;

  logic [DATA_W-1:0] pipe_data;
  logic              pipe_vld;
  logic              src_vld;
  logic [DATA_W-1:0] src_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_vld  <= 1'b0;
      pipe_data <= '0;
    end else begin
      pipe_vld <= rd_q;
      if (rd_q) pipe_data <= rword;
    end
  end

  always_comb begin
    if (mode == MODE_PIPE) begin
      src_vld  = pipe_vld;
      src_data = pipe_data;
    end else begin
      src_vld  = rd_q;
      src_data = rword;
    end
  end

  assign q_drive = src_vld && oe && !sleep;
  assign q       = q_drive ? src_data : '0;

  p_oe_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !q_drive);
  p_sleep_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !q_drive);
  p_pipe_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PIPE && $past(rd_q) && oe && !sleep) |-> q_drive);
  p_pipe_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PIPE && !$past(rd_q)) |-> !q_drive);
  p_undriven_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !q_drive |-> (q == '0));
endmodule

// File: rtl/sram_core.sv
module sram_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs_n,
  input  logic                    cs,
  input  logic                    wr_all,
  input  logic                    wr_bytes,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [LANES*LANE_W-1:0] d,
  input  logic                    pipe_mode,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_drive
);
  import sram_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  logic              selected;
  cyc_kind_e         kind;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic [DATA_W-1:0] rword;
  rd_mode_e          mode;

  assign selected = !cs_n && cs;
  assign mode     = pipe_mode ? MODE_PIPE : MODE_FLOW;

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .selected (selected),
    .sleep    (sleep),
    .wr_all   (wr_all),
    .wr_bytes (wr_bytes),
    .lane_sel (lane_sel),
    .kind     (kind),
    .lane_we  (lane_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= (kind == CYC_READ);
      if (kind == CYC_READ) addr_q <= addr;
    end
  end

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .waddr   (addr),
    .lane_we (lane_we),
    .wdata   (d),
    .raddr   (addr_q),
    .rword   (rword)
  );

  sram_out_path #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .rd_q    (rd_q),
    .rword   (rword),
    .oe      (oe),
    .sleep   (sleep),
    .q       (q),
    .q_drive (q_drive)
  );

  p_no_access_unselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && cs) |-> (lane_we == '0));
  p_global_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs && !sleep && wr_all) |-> (&lane_we));
  p_byte_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all && !wr_bytes) |-> (lane_we == '0));
  p_sleep_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0));
  p_flow_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(!(!cs_n && cs))) |-> !q_drive);
endmodule

// File: tb/test_sram_core.sv
module test_sram_core;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, cs = 1'b0;
  logic          wr_all = 1'b0, wr_bytes = 1'b0;
  logic [NL-1:0] lane_sel = '0;
  logic [DW-1:0] d = '0;
  logic          pipe_mode = 1'b1, oe = 1'b1, sleep = 1'b0;
  logic [DW-1:0] q;
  logic          q_drive;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .cs(cs),
    .wr_all(wr_all), .wr_bytes(wr_bytes), .lane_sel(lane_sel), .d(d),
    .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep), .q(q), .q_drive(q_drive)
  );

  typedef struct packed {
    logic          gw;
    logic          be;
    logic [NL-1:0] sel;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic          pm;
    logic [DW-1:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b0, 2'b00, 6'd1, 18'h12345, 1'b0, 18'h12345},  // R2
    '{1'b0, 1'b1, 2'b01, 6'd2, 18'h3FFFF, 1'b1, 18'h001FF},  // R3 lane 0
    '{1'b0, 1'b1, 2'b10, 6'd3, 18'h3FFFF, 1'b0, 18'h3FE00},  // R3 lane 1
    '{1'b0, 1'b0, 2'b11, 6'd4, 18'h3FFFF, 1'b1, 18'h00000},  // R3 no enable
    '{1'b1, 1'b1, 2'b00, 6'd5, 18'h0ABCD, 1'b1, 18'h0ABCD},  // R2 override
    '{1'b0, 1'b1, 2'b11, 6'd1, 18'h2A5A5, 1'b0, 18'h2A5A5},  // R3 both
    '{1'b0, 1'b1, 2'b01, 6'd1, 18'h00100, 1'b1, 18'h2A500}   // R10 parity
  };

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; cs = 1'b0; wr_all = 1'b0; wr_bytes = 1'b0; lane_sel = '0;
  endtask

  task automatic do_write(input logic gw, input logic be, input logic [NL-1:0] s,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd);
    cs_n = 1'b0; cs = 1'b1; addr = a; d = wd;
    wr_all = gw; wr_bytes = be; lane_sel = s;
    @(negedge clk);
    idle();
  endtask

  // Issues a read, returns the word seen in the cycle the mode predicts.
  task automatic do_read(input logic pm, input logic [AW-1:0] a,
                         output logic [DW-1:0] val, output logic drv);
    pipe_mode = pm;
    cs_n = 1'b0; cs = 1'b1; addr = a; wr_all = 1'b0; wr_bytes = 1'b0;
    @(negedge clk);
    idle();
    if (pm) @(negedge clk);
    val = q; drv = q_drive;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic dr;
    repeat (2) @(negedge clk);
    chk(q_drive == 1'b0 && q == '0, "R9 reset", {17'b0, q_drive}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 1; a <= 5; a++) do_write(1'b1, 1'b0, '0, AW'(a), '0);

    for (int i = 0; i < 7; i++) begin
      do_write(VECS[i].gw, VECS[i].be, VECS[i].sel, VECS[i].a, VECS[i].wd);
      do_read(VECS[i].pm, VECS[i].a, v, dr);
      chk(dr === 1'b1 && v === VECS[i].exp,
          VECS[i].pm ? "R5 vector" : "R4 vector", v, VECS[i].exp);
      @(negedge clk);
    end

    // R1: unselected writes leave memory untouched
    cs_n = 1'b1; cs = 1'b1; addr = 6'd2; d = 18'h3FFFF; wr_all = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; cs = 1'b0;
    @(negedge clk);
    idle();
    do_read(1'b0, 6'd2, v, dr);
    chk(v === 18'h001FF, "R1 deselected write ignored", v, 18'h001FF);
    @(negedge clk);
    cs_n = 1'b0; cs = 1'b0; addr = 6'd2;
    @(negedge clk);
    chk(q_drive == 1'b0, "R1 deselected read not driven", {17'b0, q_drive}, '0);
    idle();

    // R4 flow read appears one cycle after the edge, not during a write
    pipe_mode = 1'b0;
    cs_n = 1'b0; cs = 1'b1; addr = 6'd5;
    @(negedge clk);
    chk(q_drive && q === 18'h0ABCD, "R4 flow timing", q, 18'h0ABCD);
    wr_all = 1'b1; addr = 6'd6; d = 18'h11111;
    @(negedge clk);
    chk(q_drive == 1'b0, "R9 write cycle undriven", {17'b0, q_drive}, '0);
    idle();
    @(negedge clk);
    chk(q_drive == 1'b0, "R8 flow deselect", {17'b0, q_drive}, '0);

    // R5/R8 pipelined latency and deselect
    pipe_mode = 1'b1;
    cs_n = 1'b0; cs = 1'b1; addr = 6'd3;
    @(negedge clk);
    idle();
    chk(q_drive == 1'b0, "R5 not yet driven", {17'b0, q_drive}, '0);
    @(negedge clk);
    chk(q_drive && q === 18'h3FE00, "R8 drive after deselect edge", q, 18'h3FE00);
    @(negedge clk);
    chk(q_drive == 1'b0, "R8 pipe undriven one edge later", {17'b0, q_drive}, '0);

    // R6 asynchronous output enable
    pipe_mode = 1'b0;
    cs_n = 1'b0; cs = 1'b1; addr = 6'd5;
    @(negedge clk);
    oe = 1'b0; #1;
    chk(q_drive == 1'b0 && q == '0, "R6 oe low", q, '0);
    oe = 1'b1; #1;
    chk(q_drive && q === 18'h0ABCD, "R6 oe restored", q, 18'h0ABCD);

    // R7 asynchronous sleep, blocked write, retention
    sleep = 1'b1; #1;
    chk(q_drive == 1'b0, "R7 sleep gates output", {17'b0, q_drive}, '0);
    idle();
    @(negedge clk);
    do_write(1'b1, 1'b0, '0, 6'd5, 18'h3FFFF);
    sleep = 1'b0;
    @(negedge clk);
    do_read(1'b1, 6'd5, v, dr);
    chk(dr && v === 18'h0ABCD, "R7 data kept, sleep write blocked", v, 18'h0ABCD);
    do_read(1'b0, 6'd6, v, dr);
    chk(dr && v === 18'h11111, "R4 flow after write", v, 18'h11111);

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule